// File: doc/BRIEF.md
# Floating-Point Sign, Min/Max, Compare and Classify Unit

This block carries out the floating-point operations that need no arithmetic datapath on single-precision values. Each single-precision value sits in the low 32 bits of a wider 64-bit register word. It performs sign injection, minimum/maximum selection, ordered and equality comparison, and classification. The operation group is picked by a 2-bit selector. The variant inside the group is taken from a 3-bit mode field that shares its encoding with the rounding-mode field. A one-bit modifier changes how the sign-injection result is widened.

Each operand is checked for correct boxing before use. If the upper half of the word is not all ones, the operand is replaced by the canonical quiet NaN. A parameter can turn this check off. Floating-point results come out boxed. Integer-like results (comparison booleans, class masks) come out with zero upper bits. The sign-injection modifier instead requests sign extension of the 32-bit result. A five-bit exception vector goes with every result. An optional output register gives a fixed latency of one cycle.

Top module: `fp_noncomp_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `result` and `flags` to zero while reset is held, whatever the inputs do.
- R2: With `op_sel`=00 (sign injection) and `op_mod`=0, mode 000 returns operand A with B's sign, 001 returns A with B's inverted sign, 010 returns A with the sign A XOR B, and 011 returns A unchanged. The 32-bit result is placed under an upper half of all ones, and `flags` is zero.
- R3: With `op_sel`=00 and `op_mod`=1, the 32-bit sign-injection result is sign-extended into bits 63:32 instead of being boxed.
- R4: With `op_sel`=01, mode 000 returns the smaller and mode 001 the larger operand, boxed. If exactly one operand is NaN the other is returned. If both are NaN the result is 0x7FC00000 (boxed). Any signaling NaN input sets the invalid flag.
- R5: Minimum/maximum orders -0 below +0. Comparison treats -0 and +0 as equal.
- R6: With `op_sel`=10, mode 000 computes A<=B, 001 computes A<B and 010 computes A==B. The result is 0 or 1 in bit 0, with bits 63:1 zero.
- R7: A comparison with any NaN operand returns 0. The two ordered comparisons set the invalid flag on any NaN. Equality sets it only for a signaling NaN.
- R8: With `op_sel`=11, the result is a one-hot mask in bits 9:0, with bits 63:10 zero and flags zero. The bits are, in order from bit 0: -inf, -normal, -subnormal, -0, +0, +subnormal, +normal, +inf, signaling NaN, quiet NaN. The mode field and the modifier are ignored.
- R9: With `BOX_CHECK`=1, an operand whose bits 63:32 are not all ones is treated as the quiet NaN 0x7FC00000. With `BOX_CHECK`=0 the upper bits are ignored.
- R10: A mode code with no meaning for the selected group gives result zero with the invalid flag set. This covers 100 to 111 for sign injection, anything but 000/001 for min/max, and anything but 000/001/010 for comparison.
- R11: With `REG_OUT`=1, `out_valid`, `result` and `flags` appear one clock after the input is taken, and they hold while `in_valid` is low. With `REG_OUT`=0 they follow the inputs in the same cycle.
- R12: `flags` is ordered {invalid, divide-by-zero, overflow, underflow, inexact} from bit 4 down to bit 0. Only bit 4 can ever be set by this unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sel | input | 2 | 00 sign inject, 01 min/max, 10 compare, 11 classify |
| rm_sel | input | 3 | Variant select, in rounding-mode encoding |
| op_mod | input | 1 | Sign-injection widening: 0 boxed, 1 sign-extended |
| opa | input | 64 | Operand A (single-precision in bits 31:0) |
| opb | input | 64 | Operand B (single-precision in bits 31:0) |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Result word |
| flags | output | 5 | Exception flags {NV, DZ, OF, UF, NX} |

## Verification
Every path here is combinational up to one register. A wrong decode of the mode field or a wrong NaN/zero classification therefore shows on `result` or `flags` in the cycle right after the operation is taken. The vector walk pairs each variant with operands that sit on the corner it decides: equal magnitudes, signed zeros, negative ordering, quiet versus signaling NaN, and unboxed words. A flipped sign rule or a swapped comparison shows up within one vector. A register that loads while idle, or a valid flag that lags, shows on the hold and reset checks in the same cycle it goes wrong.

// File: rtl/fpnc_pkg.sv
package fpnc_pkg;

    localparam int FP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int CLS_W  = 10;
    localparam logic [FP_W-1:0] CANON_QNAN = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        GRP_SIGN  = 2'b00,
        GRP_MINMX = 2'b01,
        GRP_CMP   = 2'b10,
        GRP_CLASS = 2'b11
    } fpnc_grp_e;

    typedef enum logic [2:0] {
        MODE_0 = 3'b000,
        MODE_1 = 3'b001,
        MODE_2 = 3'b010,
        MODE_3 = 3'b011
    } fpnc_mode_e;

    typedef struct packed {
        logic invalid;
        logic div_zero;
        logic overflow;
        logic underflow;
        logic inexact;
    } fpnc_flags_t;

    typedef struct packed {
        logic [FP_W-1:0] val;
        logic            nan;
        logic            snan;
    } fpnc_opnd_t;

    function automatic logic mag_zero(input logic [FP_W-1:0] v);
        return v[FP_W-2:0] == '0;
    endfunction

    // Total order with -0 below +0; NaNs are handled by the caller.
    function automatic logic total_lt(input logic [FP_W-1:0] a, input logic [FP_W-1:0] b);
        if (a[FP_W-1] != b[FP_W-1]) return a[FP_W-1];
        if (a[FP_W-1])              return a[FP_W-2:0] > b[FP_W-2:0];
        return a[FP_W-2:0] < b[FP_W-2:0];
    endfunction

    function automatic logic [CLS_W-1:0] class_mask(input logic [FP_W-1:0] v);
        logic                 s;
        logic [EXP_W-1:0]     e;
        logic [MAN_W-1:0]     m;
        logic [CLS_W-1:0]     r;
        s = v[FP_W-1];
        e = v[FP_W-2:MAN_W];
        m = v[MAN_W-1:0];
        r = '0;
        if (e == '1) begin
            if (m == '0)          r[s ? 0 : 7] = 1'b1;
            else if (m[MAN_W-1])  r[9] = 1'b1;
            else                  r[8] = 1'b1;
        end else if (e == '0) begin
            if (m == '0)          r[s ? 3 : 4] = 1'b1;
            else                  r[s ? 2 : 5] = 1'b1;
        end else begin
            r[s ? 1 : 6] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/fpnc_unbox.sv
module fpnc_unbox
    import fpnc_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter bit BOX_CHECK = 1'b1
) (
    input  logic [DATA_W-1:0] raw,
    output fpnc_opnd_t        opnd
);
    localparam int HI_W = DATA_W - FP_W;

    logic            box_ok;
    logic [FP_W-1:0] v;

    generate
        if (BOX_CHECK) begin : g_chk
            assign box_ok = raw[DATA_W-1:FP_W] == {HI_W{1'b1}};
        end else begin : g_nochk
            assign box_ok = 1'b1;
        end
    endgenerate

    assign v         = box_ok ? raw[FP_W-1:0] : CANON_QNAN;
    assign opnd.val  = v;
    assign opnd.nan  = (v[FP_W-2:MAN_W] == '1) && (v[MAN_W-1:0] != '0);
    assign opnd.snan = opnd.nan && !v[MAN_W-1];
endmodule

// File: rtl/fpnc_core.sv
module fpnc_core
    import fpnc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        op_sel,
    input  logic [2:0]        rm_sel,
    input  logic              op_mod,
    input  fpnc_opnd_t        a,
    input  fpnc_opnd_t        b,
    output logic [DATA_W-1:0] res,
    output fpnc_flags_t       flg
);
    localparam int HI_W = DATA_W - FP_W;

    logic            a_lt_b, both_zero, any_nan, any_snan;
    logic            sgn;
    logic [FP_W-1:0] inj;

    assign a_lt_b    = total_lt(a.val, b.val);
    assign both_zero = mag_zero(a.val) && mag_zero(b.val);
    assign any_nan   = a.nan || b.nan;
    assign any_snan  = a.snan || b.snan;

    always_comb begin
        res = '0;
        flg = '0;
        sgn = 1'b0;
        inj = '0;
        unique case (fpnc_grp_e'(op_sel))
            GRP_SIGN: begin
                if (rm_sel[2]) begin
                    flg.invalid = 1'b1;
                end else begin
                    unique case (rm_sel[1:0])
                        2'b00: sgn = b.val[FP_W-1];
                        2'b01: sgn = ~b.val[FP_W-1];
                        2'b10: sgn = a.val[FP_W-1] ^ b.val[FP_W-1];
                        default: sgn = a.val[FP_W-1];
                    endcase
                    inj = {sgn, a.val[FP_W-2:0]};
                    res = op_mod ? {{HI_W{sgn}}, inj} : {{HI_W{1'b1}}, inj};
                end
            end
            GRP_MINMX: begin
                if (rm_sel == MODE_0 || rm_sel == MODE_1) begin
                    flg.invalid = any_snan;
                    if (a.nan && b.nan)  inj = CANON_QNAN;
                    else if (a.nan)      inj = b.val;
                    else if (b.nan)      inj = a.val;
                    else if (rm_sel[0])  inj = a_lt_b ? b.val : a.val;
                    else                 inj = a_lt_b ? a.val : b.val;
                    res = {{HI_W{1'b1}}, inj};
                end else begin
                    flg.invalid = 1'b1;
                end
            end
            GRP_CMP: begin
                unique case (rm_sel)
                    MODE_0: begin
                        flg.invalid = any_nan;
                        res[0] = !any_nan && (both_zero || a_lt_b || a.val == b.val);
                    end
                    MODE_1: begin
                        flg.invalid = any_nan;
                        res[0] = !any_nan && !both_zero && a_lt_b;
                    end
                    MODE_2: begin
                        flg.invalid = any_snan;
                        res[0] = !any_nan && (both_zero || a.val == b.val);
                    end
                    default: flg.invalid = 1'b1;
                endcase
            end
            default: begin
                res[CLS_W-1:0] = class_mask(a.val);
            end
        endcase
    end
endmodule

// File: rtl/fpnc_outstage.sv
module fpnc_outstage
    import fpnc_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_in,
    input  logic [DATA_W-1:0] res_in,
    input  fpnc_flags_t       flg_in,
    output logic              vld_out,
    output logic [DATA_W-1:0] res_out,
    output fpnc_flags_t       flg_out
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_out <= 1'b0;
                    res_out <= '0;
                    flg_out <= '0;
                end else begin
                    vld_out <= vld_in;
                    if (vld_in) begin
                        res_out <= res_in;
                        flg_out <= flg_in;
                    end
                end
            end
        end else begin : g_comb
            assign vld_out = vld_in;
            assign res_out = res_in;
            assign flg_out = flg_in;
        end
    endgenerate
endmodule

// File: rtl/fp_noncomp_unit.sv
module fp_noncomp_unit
    import fpnc_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter bit BOX_CHECK = 1'b1,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [2:0]        rm_sel,
    input  logic              op_mod,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [4:0]        flags
);
    fpnc_opnd_t        a_u, b_u;
    logic [DATA_W-1:0] res_n;
    fpnc_flags_t       flg_n, flg_q;

    fpnc_unbox #(.DATA_W(DATA_W), .BOX_CHECK(BOX_CHECK)) u_unbox_a (.raw(opa), .opnd(a_u));
    fpnc_unbox #(.DATA_W(DATA_W), .BOX_CHECK(BOX_CHECK)) u_unbox_b (.raw(opb), .opnd(b_u));

    fpnc_core #(.DATA_W(DATA_W)) u_core (
        .op_sel(op_sel), .rm_sel(rm_sel), .op_mod(op_mod),
        .a(a_u), .b(b_u), .res(res_n), .flg(flg_n)
    );

    fpnc_outstage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
        .clk(clk), .rst(rst), .vld_in(in_valid), .res_in(res_n), .flg_in(flg_n),
        .vld_out(out_valid), .res_out(result), .flg_out(flg_q)
    );

    assign flags = flg_q;

    // R12: the arithmetic-only flags never leave the unit
    p_quiet_flags_r12: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> flags[3:0] == 4'b0000);

    // R8: classification yields exactly one bit in the low ten, nothing above
    p_class_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b11) |->
        ($countones(res_n[CLS_W-1:0]) == 1 && res_n[DATA_W-1:CLS_W] == '0));

    // R6: comparison result is a single boolean bit
    p_cmp_bool_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b10) |-> res_n[DATA_W-1:1] == '0);

    // R4: a valid min/max result is always boxed
    p_minmax_boxed_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b01 && !flg_n.invalid) |-> res_n[DATA_W-1:FP_W] == '1);

    generate
        if (REG_OUT) begin : g_reg_chk
            // R11: valid tracks the input one cycle later
            p_valid_lag_r11: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> out_valid == $past(in_valid));
            // R11: an idle cycle leaves the result untouched
            p_hold_r11: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(result) && $stable(flags));
        end
    endgenerate
endmodule

// File: tb/fp_noncomp_unit_tb.sv
`timescale 1ns/1ps
module fp_noncomp_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [2:0]  rm_sel = '0;
    logic        op_mod = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic        out_valid, raw_valid;
    logic [63:0] result, raw_result;
    logic [4:0]  flags, raw_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    fp_noncomp_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .rm_sel(rm_sel),
        .op_mod(op_mod), .opa(opa), .opb(opb),
        .out_valid(out_valid), .result(result), .flags(flags)
    );

    fp_noncomp_unit #(.BOX_CHECK(1'b0), .REG_OUT(1'b0)) u_dut_raw (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .rm_sel(rm_sel),
        .op_mod(op_mod), .opa(opa), .opb(opb),
        .out_valid(raw_valid), .result(raw_result), .flags(raw_flags)
    );

    localparam logic [31:0] HI  = 32'hFFFF_FFFF;
    localparam logic [63:0] P1  = {HI, 32'h3F80_0000};
    localparam logic [63:0] N2  = {HI, 32'hC000_0000};
    localparam logic [63:0] N3  = {HI, 32'hC040_0000};
    localparam logic [63:0] PZ  = {HI, 32'h0000_0000};
    localparam logic [63:0] NZ  = {HI, 32'h8000_0000};
    localparam logic [63:0] PI  = {HI, 32'h7F80_0000};
    localparam logic [63:0] NI  = {HI, 32'hFF80_0000};
    localparam logic [63:0] QN  = {HI, 32'h7FC0_0000};
    localparam logic [63:0] SN  = {HI, 32'h7F80_0001};
    localparam logic [63:0] PS  = {HI, 32'h0000_0001};
    localparam logic [63:0] NS  = {HI, 32'h8000_0001};
    localparam logic [63:0] UB1 = {32'h0000_0000, 32'h3F80_0000};
    localparam logic [4:0]  NV  = 5'b10000;

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  op;
        logic [2:0]  rm;
        logic        md;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] er;
        logic [4:0]  ef;
    } vec_t;

    localparam int NV_CNT = 35;
    localparam vec_t VECS [NV_CNT] = '{
        '{8'd2,  2'd0, 3'd0, 1'b0, P1, N2, {HI, 32'hBF80_0000}, 5'd0}, // R2 copy sign
        '{8'd2,  2'd0, 3'd1, 1'b0, P1, N2, P1, 5'd0},                  // R2 inverted sign
        '{8'd2,  2'd0, 3'd2, 1'b0, N2, N2, {HI, 32'h4000_0000}, 5'd0}, // R2 xor sign
        '{8'd2,  2'd0, 3'd3, 1'b0, N2, P1, N2, 5'd0},                  // R2 passthrough
        '{8'd3,  2'd0, 3'd0, 1'b1, N2, P1, 64'h0000_0000_4000_0000, 5'd0}, // R3
        '{8'd3,  2'd0, 3'd1, 1'b1, P1, P1, 64'hFFFF_FFFF_BF80_0000, 5'd0}, // R3
        '{8'd4,  2'd1, 3'd0, 1'b0, P1, N2, N2, 5'd0},                  // R4 min
        '{8'd4,  2'd1, 3'd1, 1'b0, P1, N2, P1, 5'd0},                  // R4 max
        '{8'd5,  2'd1, 3'd0, 1'b0, PZ, NZ, NZ, 5'd0},                  // R5 min zeros
        '{8'd5,  2'd1, 3'd1, 1'b0, NZ, PZ, PZ, 5'd0},                  // R5 max zeros
        '{8'd4,  2'd1, 3'd0, 1'b0, QN, P1, P1, 5'd0},                  // R4 one qNaN
        '{8'd4,  2'd1, 3'd1, 1'b0, SN, N2, N2, NV},                    // R4 sNaN
        '{8'd4,  2'd1, 3'd0, 1'b0, QN, SN, QN, NV},                    // R4 both NaN
        '{8'd6,  2'd2, 3'd0, 1'b0, P1, P1, 64'd1, 5'd0},               // R6 le equal
        '{8'd6,  2'd2, 3'd1, 1'b0, P1, P1, 64'd0, 5'd0},               // R6 lt equal
        '{8'd6,  2'd2, 3'd1, 1'b0, N2, P1, 64'd1, 5'd0},               // R6 lt
        '{8'd6,  2'd2, 3'd1, 1'b0, N2, N3, 64'd0, 5'd0},               // R6 negatives
        '{8'd5,  2'd2, 3'd2, 1'b0, PZ, NZ, 64'd1, 5'd0},               // R5 eq zeros
        '{8'd7,  2'd2, 3'd2, 1'b0, QN, P1, 64'd0, 5'd0},               // R7 eq qNaN
        '{8'd7,  2'd2, 3'd0, 1'b0, QN, P1, 64'd0, NV},                 // R7 le qNaN
        '{8'd7,  2'd2, 3'd2, 1'b0, SN, P1, 64'd0, NV},                 // R7 eq sNaN
        '{8'd8,  2'd3, 3'd0, 1'b0, NI, PZ, 64'h001, 5'd0},             // R8
        '{8'd8,  2'd3, 3'd7, 1'b1, N2, PZ, 64'h002, 5'd0},             // R8 mode ignored
        '{8'd8,  2'd3, 3'd0, 1'b0, NS, PZ, 64'h004, 5'd0},             // R8
        '{8'd8,  2'd3, 3'd0, 1'b0, NZ, PZ, 64'h008, 5'd0},             // R8
        '{8'd8,  2'd3, 3'd0, 1'b0, PZ, PZ, 64'h010, 5'd0},             // R8
        '{8'd8,  2'd3, 3'd0, 1'b0, PS, PZ, 64'h020, 5'd0},             // R8
        '{8'd8,  2'd3, 3'd0, 1'b0, P1, PZ, 64'h040, 5'd0},             // R8
        '{8'd8,  2'd3, 3'd0, 1'b0, PI, PZ, 64'h080, 5'd0},             // R8
        '{8'd8,  2'd3, 3'd0, 1'b0, SN, PZ, 64'h100, 5'd0},             // R8
        '{8'd8,  2'd3, 3'd0, 1'b0, QN, PZ, 64'h200, 5'd0},             // R8
        '{8'd9,  2'd3, 3'd0, 1'b0, UB1, PZ, 64'h200, 5'd0},            // R9 unboxed
        '{8'd9,  2'd0, 3'd3, 1'b0, UB1, P1, QN, 5'd0},                 // R9 unboxed
        '{8'd10, 2'd0, 3'd7, 1'b0, P1, P1, 64'd0, NV},                 // R10
        '{8'd10, 2'd1, 3'd2, 1'b0, P1, N2, 64'd0, NV}                  // R10
    };

    task automatic check(input int req, input string what,
                         input logic [63:0] gr, input logic [63:0] er,
                         input logic [4:0] gf, input logic [4:0] ef);
        n_chk++;
        if (gr !== er || gf !== ef) begin
            n_bad++;
            $display("FAIL R%0d %s: result=%h flags=%b expected result=%h flags=%b",
                     req, what, gr, gf, er, ef);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] o, input logic [2:0] r,
                         input logic m, input logic [63:0] a, input logic [63:0] b);
        in_valid = v; op_sel = o; rm_sel = r; op_mod = m; opa = a; opb = b;
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            finish_up();
        end
    end

    initial begin
        // R1: reset holds outputs at zero even with traffic present
        @(negedge clk);
        drive(1'b1, 2'd3, 3'd0, 1'b0, P1, P1);
        repeat (2) @(negedge clk);
        check(1, "reset state", result, 64'd0, flags, 5'd0);
        check(1, "reset valid", {63'd0, out_valid}, 64'd0, 5'd0, 5'd0);
        rst = 1'b0;
        drive(1'b0, 2'd0, 3'd0, 1'b0, PZ, PZ);
        @(negedge clk);

        // Table walk: one-cycle registered latency
        foreach (VECS[i]) begin
            drive(1'b1, VECS[i].op, VECS[i].rm, VECS[i].md, VECS[i].a, VECS[i].b);
            @(negedge clk);
            check(int'(VECS[i].req), $sformatf("vector %0d", i),
                  result, VECS[i].er, flags, VECS[i].ef);
            check(11, "valid after take", {63'd0, out_valid}, 64'd1, 5'd0, 5'd0);
        end

        // R11: idle cycle holds previous output (last vector left 0 / NV)
        drive(1'b0, 2'd3, 3'd0, 1'b0, P1, P1);
        @(negedge clk);
        check(11, "hold while idle", result, 64'd0, flags, NV);
        check(11, "valid drops", {63'd0, out_valid}, 64'd0, 5'd0, 5'd0);

        // R12: invalid flag lands in bit 4 only
        drive(1'b1, 2'd2, 3'd1, 1'b0, SN, P1);
        @(negedge clk);
        check(12, "NV position", {59'd0, flags}, 64'h10, 5'd0, 5'd0);

        // R10: compare with unused mode 011
        drive(1'b1, 2'd2, 3'd3, 1'b0, P1, P1);
        @(negedge clk);
        check(10, "cmp bad mode", result, 64'd0, flags, NV);

        // R9 / R11: box check off, combinational instance follows same cycle
        drive(1'b1, 2'd3, 3'd0, 1'b0, UB1, PZ);
        #1;
        check(9, "no box check classify", raw_result, 64'h040, raw_flags, 5'd0);
        check(11, "comb valid", {63'd0, raw_valid}, 64'd1, 5'd0, 5'd0);
        drive(1'b0, 2'd2, 3'd1, 1'b0, {32'h0, 32'hC000_0000}, UB1);
        #1;
        check(9, "no box check compare", raw_result, 64'd1, raw_flags, 5'd0);
        check(11, "comb valid low", {63'd0, raw_valid}, 64'd0, 5'd0, 5'd0);

        // R1: reset mid-run clears registered outputs
        @(negedge clk);
        rst = 1'b1;
        drive(1'b1, 2'd1, 3'd1, 1'b0, P1, N2);
        @(negedge clk);
        check(1, "reset mid-run", result, 64'd0, flags, 5'd0);
        rst = 1'b0;

        done = 1'b1;
        finish_up();
    end
endmodule